// File: doc/BRIEF.md
# Two-Wire Controller Register Bank

This block is the software-visible register file of a two-wire serial bus controller. A CPU reaches it through a simple request port carrying a byte offset, write and read strobes, an access size in bytes and 16-bit write data. Eighteen 16-bit slots sit on a 4-byte stride. Two of them are reserved. The rest are configuration words, sticky status words, live status inputs and the transmit and receive data windows. The serial engine and the data FIFOs live outside the block and connect through event inputs, live status inputs, a transmit holding output with a push strobe, and a receive data input with a pop strobe.

Every access is judged in a fixed order. A size other than two bytes is a size error and overrides everything else. After that, an offset that is misaligned, reserved or past the last slot is a map error. Only accesses that pass both checks reach a register. Read data, error pulses and FIFO strobes are all registered, so they appear one clock after the request.

Top module: `twi_reg_bank`

## Requirements
- R1: After reset every stored register, `tx_data_o`, `rdata_o`, both error pulses and both FIFO strobes are zero.
- R2: Only `size_i` = 2 is legal. Any other size pulses `err_size_o` for one cycle, never `err_map_o`, even at an unmapped offset. A write of the wrong size is dropped, and a read of the wrong size returns 0.
- R3: Slot index is `addr_i[6:2]`. Slots in order: 0 clock divider, 1 control, 2 slave control, 3 slave status, 4 slave address, 5 master control, 6 master status, 7 master address, 8 interrupt status, 9 interrupt mask, 10 FIFO control, 11 FIFO status, 12–13 reserved, 14 transmit 8-bit, 15 transmit 16-bit, 16 receive 8-bit, 17 receive 16-bit. A legal-size access with `addr_i[1:0]` ≠ 0, or to slot 12, 13 or 18 and above, pulses `err_map_o`, reads 0 and writes nothing.
- R4: Slots 0, 1, 2, 4, 5, 7, 9 and 10 store the full 16-bit write value and read it back.
- R5: Interrupt status bit i sets when `irq_evt_i[i]` is high. A write clears each bit written as 1 and leaves bits written as 0 unchanged. A set and a clear on the same bit in the same cycle leave the bit set.
- R6: Master status bits 0..4 (0 buffer write error, 1 buffer read error, 2 data NAK, 3 address NAK, 4 lost arbitration) set from `mst_evt_i` and clear when written as 1, and a set wins over a clear in the same cycle. Bits 15:5 read `mst_live_i` and ignore writes.
- R7: Slave status reads `slv_stat_i` and FIFO status reads `fifo_stat_i`. Writes to these two slots and to the receive slots are dropped without an error.
- R8: A legal write to slot 14 or 15 loads `tx_data_o` with `wdata_i` and pulses `tx_push_o` one cycle later. A read of either slot returns 0.
- R9: A legal read of slot 16 or 17 returns `rx_data_i` as sampled at the request edge and pulses `rx_pop_o`.
- R10: `rdata_o` carries read data in the cycle after a read request and is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 7 | Byte offset of the access |
| wr_i | input | 1 | Write request |
| rd_i | input | 1 | Read request |
| size_i | input | 3 | Access size in bytes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| err_size_o | output | 1 | Wrong-size access pulse |
| err_map_o | output | 1 | Unmapped-offset access pulse |
| irq_evt_i | input | 16 | Interrupt status set events |
| mst_evt_i | input | 5 | Master error set events |
| mst_live_i | input | 11 | Live master status bits 15:5 |
| slv_stat_i | input | 16 | Live slave status |
| fifo_stat_i | input | 16 | Live FIFO status |
| tx_data_o | output | 16 | Transmit holding value |
| tx_push_o | output | 1 | Transmit push strobe |
| rx_data_i | input | 16 | Receive data from FIFO |
| rx_pop_o | output | 1 | Receive pop strobe |

## Verification
Two functions can act on the same cycle: a hardware event setting a sticky status bit, and a CPU write-one-to-clear hitting that same bit. The bench pulses `irq_evt_i` or `mst_evt_i` in the exact cycle that it drives the clearing write. It then reads the register back and expects the contested bit still set, while bits that were only cleared must read zero. A second clearing write with no event present must then remove the bit.

// File: rtl/twi_reg_pkg.sv
package twi_reg_pkg;
  localparam int SLOT_W    = 5;
  localparam int ADDR_W    = SLOT_W + 2;
  localparam int NUM_SLOTS = 18;
  localparam int LEGAL_BYTES = 2;

  localparam logic [SLOT_W-1:0] SL_CLKDIV = 5'd0;
  localparam logic [SLOT_W-1:0] SL_CTRL   = 5'd1;
  localparam logic [SLOT_W-1:0] SL_SCTL   = 5'd2;
  localparam logic [SLOT_W-1:0] SL_SSTAT  = 5'd3;
  localparam logic [SLOT_W-1:0] SL_SADDR  = 5'd4;
  localparam logic [SLOT_W-1:0] SL_MCTL   = 5'd5;
  localparam logic [SLOT_W-1:0] SL_MSTAT  = 5'd6;
  localparam logic [SLOT_W-1:0] SL_MADDR  = 5'd7;
  localparam logic [SLOT_W-1:0] SL_ISTAT  = 5'd8;
  localparam logic [SLOT_W-1:0] SL_IMASK  = 5'd9;
  localparam logic [SLOT_W-1:0] SL_FCTL   = 5'd10;
  localparam logic [SLOT_W-1:0] SL_FSTAT  = 5'd11;
  localparam logic [SLOT_W-1:0] SL_RSV0   = 5'd12;
  localparam logic [SLOT_W-1:0] SL_RSV1   = 5'd13;
  localparam logic [SLOT_W-1:0] SL_TX8    = 5'd14;
  localparam logic [SLOT_W-1:0] SL_TX16   = 5'd15;
  localparam logic [SLOT_W-1:0] SL_RX8    = 5'd16;
  localparam logic [SLOT_W-1:0] SL_RX16   = 5'd17;

  localparam int N_PLAIN = 8;
  localparam logic [SLOT_W-1:0] PLAIN_SLOT [N_PLAIN] = '{
    SL_CLKDIV, SL_CTRL, SL_SCTL, SL_SADDR, SL_MCTL, SL_MADDR, SL_IMASK, SL_FCTL
  };

  // master status sticky error bits
  localparam int MS_BUF_WR_ERR = 0;
  localparam int MS_BUF_RD_ERR = 1;
  localparam int MS_DATA_NAK   = 2;
  localparam int MS_ADDR_NAK   = 3;
  localparam int MS_LOST_ARB   = 4;
  localparam int MS_STICKY_W   = 5;
endpackage

// File: rtl/twi_addr_dec.sv
module twi_addr_dec
  import twi_reg_pkg::*;
#(
  parameter int SW = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [SW-1:0]     size_i,
  output logic              size_ok_o,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic aligned, in_range, reserved;

  always_comb begin
    slot_o    = addr_i[ADDR_W-1:2];
    size_ok_o = (size_i == SW'(LEGAL_BYTES));
    aligned   = (addr_i[1:0] == 2'b00);
    in_range  = (slot_o < SLOT_W'(NUM_SLOTS));
    reserved  = (slot_o == SL_RSV0) || (slot_o == SL_RSV1);
    hit_o     = aligned && in_range && !reserved;
  end
endmodule

// File: rtl/twi_rw_reg.sv
module twi_rw_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/twi_w1c_reg.sv
module twi_w1c_reg #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] clr_mask;

  assign clr_mask = clr_we_i ? clr_data_i : '0;

  // set applied after clear so a colliding event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_mask) | set_i;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_we_i && set_i == '0) |=> $stable(q_o)); // R6
  AST_ZERO_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && set_i == '0) |=> ((q_o & ~$past(clr_data_i)) == ($past(q_o) & ~$past(clr_data_i)))); // R5
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank
  import twi_reg_pkg::*;
#(
  parameter int DW = 16,
  parameter int SW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [SW-1:0]     size_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              err_size_o,
  output logic              err_map_o,
  input  logic [DW-1:0]     irq_evt_i,
  input  logic [MS_STICKY_W-1:0] mst_evt_i,
  input  logic [DW-MS_STICKY_W-1:0] mst_live_i,
  input  logic [DW-1:0]     slv_stat_i,
  input  logic [DW-1:0]     fifo_stat_i,
  output logic [DW-1:0]     tx_data_o,
  output logic              tx_push_o,
  input  logic [DW-1:0]     rx_data_i,
  output logic              rx_pop_o
);
  localparam logic [ADDR_W-1:0] OFS_TX8 = {SL_TX8, 2'b00};
  localparam logic [ADDR_W-1:0] OFS_RX8 = {SL_RX8, 2'b00};

  logic              size_ok, hit, acc, wr_ok, rd_ok;
  logic [SLOT_W-1:0] slot;
  logic [DW-1:0]     plain_q [N_PLAIN];
  logic [MS_STICKY_W-1:0] mst_q;
  logic [DW-1:0]     irq_q;
  logic [DW-1:0]     rd_val;
  logic              is_tx, is_rx, push_d, pop_d;

  twi_addr_dec #(.SW(SW)) u_dec (
    .addr_i   (addr_i),
    .size_i   (size_i),
    .size_ok_o(size_ok),
    .hit_o    (hit),
    .slot_o   (slot)
  );

  assign acc   = wr_i | rd_i;
  assign wr_ok = wr_i & size_ok & hit;
  assign rd_ok = rd_i & size_ok & hit;
  assign is_tx = (slot == SL_TX8) || (slot == SL_TX16);
  assign is_rx = (slot == SL_RX8) || (slot == SL_RX16);
  assign push_d = wr_ok & is_tx;
  assign pop_d  = rd_ok & is_rx;

  for (genvar g = 0; g < N_PLAIN; g++) begin : g_plain
    twi_rw_reg #(.W(DW)) u_reg (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .we_i  (wr_ok && slot == PLAIN_SLOT[g]),
      .d_i   (wdata_i),
      .q_o   (plain_q[g])
    );
  end

  twi_w1c_reg #(.W(MS_STICKY_W)) u_mst (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (mst_evt_i),
    .clr_we_i  (wr_ok && slot == SL_MSTAT),
    .clr_data_i(wdata_i[MS_STICKY_W-1:0]),
    .q_o       (mst_q)
  );

  twi_w1c_reg #(.W(DW)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (irq_evt_i),
    .clr_we_i  (wr_ok && slot == SL_ISTAT),
    .clr_data_i(wdata_i),
    .q_o       (irq_q)
  );

  always_comb begin
    rd_val = '0;
    for (int g = 0; g < N_PLAIN; g++) begin
      if (slot == PLAIN_SLOT[g]) rd_val = plain_q[g];
    end
    case (slot)
      SL_SSTAT:        rd_val = slv_stat_i;
      SL_FSTAT:        rd_val = fifo_stat_i;
      SL_MSTAT:        rd_val = {mst_live_i, mst_q};
      SL_ISTAT:        rd_val = irq_q;
      SL_RX8, SL_RX16: rd_val = rx_data_i;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      err_size_o <= 1'b0;
      err_map_o  <= 1'b0;
      tx_data_o  <= '0;
      tx_push_o  <= 1'b0;
      rx_pop_o   <= 1'b0;
    end else begin
      rdata_o    <= rd_ok ? rd_val : '0;
      err_size_o <= acc & ~size_ok;
      err_map_o  <= acc & size_ok & ~hit;
      tx_push_o  <= push_d;
      rx_pop_o   <= pop_d;
      if (push_d) tx_data_o <= wdata_i;
    end
  end

  AST_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({err_size_o, err_map_o})); // R2
  AST_SIZE_PRIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && size_i != SW'(LEGAL_BYTES)) |=> (err_size_o && !err_map_o && rdata_o == '0)); // R2
  AST_BAD_SIZE_NO_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i != SW'(LEGAL_BYTES)) |=> (!tx_push_o && $stable(tx_data_o))); // R2
  AST_UNMAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_map_o |-> (rdata_o == '0)); // R3
  AST_TX_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i == SW'(LEGAL_BYTES) && addr_i == OFS_TX8) |=> (tx_push_o && tx_data_o == $past(wdata_i))); // R8
  AST_TX_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && size_i == SW'(LEGAL_BYTES) && addr_i == OFS_TX8) |=> (rdata_o == '0)); // R8
  AST_RX_POP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && size_i == SW'(LEGAL_BYTES) && addr_i == OFS_RX8) |=> (rx_pop_o && rdata_o == $past(rx_data_i))); // R9
  AST_IDLE_RDATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0)); // R10
endmodule

// File: tb/twi_reg_bank_tb_top.sv
`timescale 1ns/1ps
module twi_reg_bank_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [6:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [2:0]  size_i = 3'd2;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        err_size_o, err_map_o;
  logic [15:0] irq_evt_i = '0;
  logic [4:0]  mst_evt_i = '0;
  logic [10:0] mst_live_i = '0;
  logic [15:0] slv_stat_i = '0, fifo_stat_i = '0;
  logic [15:0] tx_data_o;
  logic        tx_push_o;
  logic [15:0] rx_data_i = '0;
  logic        rx_pop_o;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] s_rdata, s_tx;
  logic        s_es, s_em, s_push, s_pop;

  always #4 clk = ~clk;

  twi_reg_bank dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i),
    .size_i(size_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .err_size_o(err_size_o), .err_map_o(err_map_o), .irq_evt_i(irq_evt_i),
    .mst_evt_i(mst_evt_i), .mst_live_i(mst_live_i), .slv_stat_i(slv_stat_i),
    .fifo_stat_i(fifo_stat_i), .tx_data_o(tx_data_o), .tx_push_o(tx_push_o),
    .rx_data_i(rx_data_i), .rx_pop_o(rx_pop_o)
  );

  typedef struct packed {
    logic        wr;
    logic        rd;
    logic [2:0]  sz;
    logic [6:0]  a;
    logic [15:0] wd;
    logic [15:0] exp;
    logic        es;
    logic        em;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 3'd2, 7'h00, 16'h1234, 16'h0000, 1'b0, 1'b0}, // R4
    '{1'b0, 1'b1, 3'd2, 7'h00, 16'h0000, 16'h1234, 1'b0, 1'b0}, // R4
    '{1'b1, 1'b0, 3'd2, 7'h24, 16'hBEEF, 16'h0000, 1'b0, 1'b0}, // R4
    '{1'b0, 1'b1, 3'd2, 7'h24, 16'h0000, 16'hBEEF, 1'b0, 1'b0}, // R4
    '{1'b1, 1'b0, 3'd2, 7'h28, 16'h00FF, 16'h0000, 1'b0, 1'b0}, // R4
    '{1'b0, 1'b1, 3'd2, 7'h28, 16'h0000, 16'h00FF, 1'b0, 1'b0}, // R4
    '{1'b1, 1'b0, 3'd2, 7'h1C, 16'h8001, 16'h0000, 1'b0, 1'b0}, // R4
    '{1'b0, 1'b1, 3'd2, 7'h1C, 16'h0000, 16'h8001, 1'b0, 1'b0}, // R4
    '{1'b1, 1'b0, 3'd1, 7'h04, 16'h5555, 16'h0000, 1'b1, 1'b0}, // R2
    '{1'b0, 1'b1, 3'd2, 7'h04, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R2 write dropped
    '{1'b0, 1'b1, 3'd4, 7'h00, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R2
    '{1'b0, 1'b1, 3'd2, 7'h30, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R3
    '{1'b1, 1'b0, 3'd2, 7'h34, 16'hFFFF, 16'h0000, 1'b0, 1'b1}, // R3
    '{1'b0, 1'b1, 3'd2, 7'h7C, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R3
    '{1'b0, 1'b1, 3'd1, 7'h31, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R2 priority
    '{1'b0, 1'b1, 3'd2, 7'h02, 16'h0000, 16'h0000, 1'b0, 1'b1}, // R3 misaligned
    '{1'b1, 1'b0, 3'd2, 7'h38, 16'hA5A5, 16'h0000, 1'b0, 1'b0}, // R8
    '{1'b0, 1'b1, 3'd2, 7'h38, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R8
    '{1'b0, 1'b1, 3'd2, 7'h3C, 16'h0000, 16'h0000, 1'b0, 1'b0}  // R8
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // drive at a falling edge, sample at the next falling edge
  task automatic access(input logic w, input logic r, input logic [2:0] sz,
                        input logic [6:0] a, input logic [15:0] wd);
    wr_i = w; rd_i = r; size_i = sz; addr_i = a; wdata_i = wd;
    @(negedge clk);
    s_rdata = rdata_o; s_es = err_size_o; s_em = err_map_o;
    s_push = tx_push_o; s_pop = rx_pop_o; s_tx = tx_data_o;
    wr_i = 1'b0; rd_i = 1'b0; size_i = 3'd2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rdata", rdata_o, 16'h0);
    chk("R1 tx_data", tx_data_o, 16'h0);
    chk("R1 strobes", {12'h0, err_size_o, err_map_o, tx_push_o, rx_pop_o}, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk);
    access(1'b0, 1'b1, 3'd2, 7'h00, 16'h0);
    chk("R1 clkdiv", s_rdata, 16'h0);
    access(1'b0, 1'b1, 3'd2, 7'h20, 16'h0);
    chk("R1 istat", s_rdata, 16'h0);
    access(1'b0, 1'b1, 3'd2, 7'h18, 16'h0);
    chk("R1 mstat", s_rdata, 16'h0);

    for (int i = 0; i < NV; i++) begin
      access(VECS[i].wr, VECS[i].rd, VECS[i].sz, VECS[i].a, VECS[i].wd);
      chk($sformatf("R2/R3/R4/R8 vec%0d rdata", i), s_rdata, VECS[i].exp);
      chk($sformatf("R2/R3 vec%0d errs", i), {14'h0, s_es, s_em}, {14'h0, VECS[i].es, VECS[i].em});
    end

    // R8 push strobe and holding value
    access(1'b1, 1'b0, 3'd2, 7'h3C, 16'hC3C3);
    chk("R8 push", {15'h0, s_push}, 16'h1);
    chk("R8 tx_data", s_tx, 16'hC3C3);
    @(negedge clk);
    chk("R8 push one cycle", {15'h0, tx_push_o}, 16'h0);
    access(1'b1, 1'b0, 3'd3, 7'h3C, 16'h1111);
    chk("R2 bad size no load", s_tx, 16'hC3C3);

    // R9 receive reads
    rx_data_i = 16'h7E81;
    access(1'b0, 1'b1, 3'd2, 7'h40, 16'h0);
    chk("R9 rx8 data", s_rdata, 16'h7E81);
    chk("R9 pop", {15'h0, s_pop}, 16'h1);
    rx_data_i = 16'h0F5A;
    access(1'b0, 1'b1, 3'd2, 7'h44, 16'h0);
    chk("R9 rx16 data", s_rdata, 16'h0F5A);
    @(negedge clk);
    chk("R10 rdata idle", rdata_o, 16'h0);

    // R7 read-only slots
    slv_stat_i = 16'h0F0F; fifo_stat_i = 16'h3300;
    access(1'b1, 1'b0, 3'd2, 7'h0C, 16'hFFFF);
    chk("R7 no err on RO write", {14'h0, s_es, s_em}, 16'h0);
    access(1'b0, 1'b1, 3'd2, 7'h0C, 16'h0);
    chk("R7 slave status", s_rdata, 16'h0F0F);
    access(1'b1, 1'b0, 3'd2, 7'h2C, 16'hFFFF);
    access(1'b0, 1'b1, 3'd2, 7'h2C, 16'h0);
    chk("R7 fifo status", s_rdata, 16'h3300);
    access(1'b1, 1'b0, 3'd2, 7'h40, 16'hFFFF);
    chk("R7 rx write no pop", {15'h0, s_pop}, 16'h0);

    // R5 interrupt status
    irq_evt_i = 16'h00F0;
    @(negedge clk);
    irq_evt_i = 16'h0;
    access(1'b0, 1'b1, 3'd2, 7'h20, 16'h0);
    chk("R5 set", s_rdata, 16'h00F0);
    access(1'b1, 1'b0, 3'd2, 7'h20, 16'h0030);
    access(1'b0, 1'b1, 3'd2, 7'h20, 16'h0);
    chk("R5 partial clear", s_rdata, 16'h00C0);
    irq_evt_i = 16'h0040;
    access(1'b1, 1'b0, 3'd2, 7'h20, 16'h0040);
    irq_evt_i = 16'h0;
    access(1'b0, 1'b1, 3'd2, 7'h20, 16'h0);
    chk("R5 set wins", s_rdata, 16'h00C0);
    access(1'b1, 1'b0, 3'd2, 7'h20, 16'hFFFF);
    access(1'b0, 1'b1, 3'd2, 7'h20, 16'h0);
    chk("R5 full clear", s_rdata, 16'h0000);

    // R6 master status
    mst_live_i = 11'h005;
    mst_evt_i = 5'h1F;
    @(negedge clk);
    mst_evt_i = 5'h0;
    access(1'b0, 1'b1, 3'd2, 7'h18, 16'h0);
    chk("R6 set plus live", s_rdata, 16'h00BF);
    access(1'b1, 1'b0, 3'd2, 7'h18, 16'hFFFF);
    access(1'b0, 1'b1, 3'd2, 7'h18, 16'h0);
    chk("R6 clear only sticky", s_rdata, 16'h00A0);
    mst_evt_i = 5'h04;
    access(1'b1, 1'b0, 3'd2, 7'h18, 16'h0004);
    mst_evt_i = 5'h0;
    access(1'b0, 1'b1, 3'd2, 7'h18, 16'h0);
    chk("R6 set wins", s_rdata, 16'h00A4);
    access(1'b1, 1'b0, 3'd2, 7'h18, 16'h0004);
    access(1'b0, 1'b1, 3'd2, 7'h18, 16'h0);
    chk("R6 clear after", s_rdata, 16'h00A0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule